// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Matcher

This block takes an interrupt command issued by one local interrupt unit and works out which of `NUM_UNITS` local units receive it. The command is written as two 32-bit words: the high word carries the destination byte, the low word carries the vector, the delivery mode, the addressing mode, the level and trigger bits and a shorthand selector. Writing the low word launches the command.

Each unit supplies its 8-bit physical ID and 8-bit logical ID on input pins. Each unit also holds a small destination-format register that selects how its logical ID is compared: a flat bitmask or a cluster nibble match. For each launch the block compares the command against every unit at once. It then drives a one-cycle delivery strobe per unit, along with the vector, level, trigger and lowest-priority information. Lowest-priority delivery narrows the matching set to one unit, the one with the highest index. Modes other than fixed and lowest-priority produce no strobe.

A command is taken in one cycle and there is no back-pressure: a launch may be issued on every clock, and a strobe is never held or retried. Priority arbitration inside the receiving units and the software register bus are not part of this block.

Top module: `ipi_dest_matcher`

## Requirements
- R1: The low word is decoded as vector [7:0], delivery mode [10:8], logical addressing bit 11, level bit 14, trigger bit 15 and shorthand [19:18]. The stored low word reads back on `cmd_lo_rd` with bit 12 always zero.
- R2: Shorthand 1 (self) matches only the unit whose index equals `src_unit`.
- R3: Shorthand 2 matches every unit. Shorthand 3 matches every unit except `src_unit`.
- R4: With shorthand 0 and bit 11 clear (physical), a unit matches when the destination byte is 0xFF or equals that unit's physical ID.
- R5: Each unit's format register resets to 0xFFFFFFFF. A write stores the 4-bit model in bits [31:28] and reads back with bits [27:0] all ones. Model 0xF selects flat, model 0x0 selects cluster, and any other model matches nothing under logical addressing.
- R6: Flat logical match: the bitwise AND of the unit's logical ID and the destination byte is nonzero.
- R7: Cluster logical match: the upper nibbles of the logical ID and the destination are equal, and the AND of their lower nibbles is nonzero.
- R8: For delivery mode 1 (lowest priority), only the highest-indexed matching unit is strobed, and `dlv_lowest` is 1. With no match, nothing is strobed.
- R9: Only delivery mode 0 (fixed) and mode 1 produce strobes. Modes 2 to 7 produce none.
- R10: Strobes appear in the cycle after the low-word write and last exactly one cycle. A high-word write in the same cycle as the low-word write supplies the destination. A format write in that same cycle takes effect only for later commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_wr_en | input | 1 | High-word write strobe |
| hi_wr_dest | input | 8 | High-word destination byte (bits 31:24) |
| lo_wr_en | input | 1 | Low-word write strobe; launches the command |
| lo_wr_data | input | 32 | Low-word data |
| src_unit | input | IDX_W | Index of the sending unit |
| unit_phys_id | input | 8*NUM_UNITS | Physical ID of each unit, unit i in bits [8i+7:8i] |
| unit_log_id | input | 8*NUM_UNITS | Logical ID of each unit |
| fmt_wr_en | input | NUM_UNITS | Per-unit format register write strobe |
| fmt_wr_model | input | 4 | Format model written (bits 31:28) |
| fmt_rd | output | 32*NUM_UNITS | Format register readback per unit |
| cmd_lo_rd | output | 32 | Stored low word, bit 12 zero |
| dlv_strobe | output | NUM_UNITS | One-cycle delivery strobe per unit |
| dlv_vector | output | 8 | Vector of the last launched command |
| dlv_level | output | 1 | Level bit of the last launched command |
| dlv_trig | output | 1 | Trigger bit of the last launched command |
| dlv_lowest | output | 1 | Last launch used lowest-priority mode |

## Verification
The hardest situation to reach from the ports is a launch where several matching rules interact. Examples are a cluster match where some units hold an unknown format model, a lowest-priority launch whose match set is empty, and a high-word or format write landing in the same cycle as the launch. The stimulus rewrites logical IDs and format models between launches to reach these cases. It also issues deliberate same-cycle writes. A behavioural model in the bench predicts every strobe, field and readback, and the bench compares them on every clock.

// File: rtl/ipi_match_pkg.sv
package ipi_match_pkg;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWEST = 3'd1;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;

  localparam int unsigned BUSY_BIT = 12;

  typedef struct packed {
    logic [7:0] dest;
    shorthand_e sh;
    logic       trig;
    logic       level;
    logic       logical;
    logic [2:0] mode;
    logic [7:0] vector;
  } ipi_cmd_t;

  function automatic ipi_cmd_t decode_cmd(input logic [31:0] lo, input logic [7:0] dest);
    ipi_cmd_t c;
    c.vector  = lo[7:0];
    c.mode    = lo[10:8];
    c.logical = lo[11];
    c.level   = lo[14];
    c.trig    = lo[15];
    c.sh      = shorthand_e'(lo[19:18]);
    c.dest    = dest;
    return c;
  endfunction

endpackage

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_match_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hi_wr_en,
  input  logic [7:0]  hi_wr_dest,
  input  logic        lo_wr_en,
  input  logic [31:0] lo_wr_data,
  output ipi_cmd_t    cmd,
  output logic [31:0] cmd_lo_rd
);
  logic [7:0]  dest_q;
  logic [31:0] lo_q;
  logic [7:0]  dest_eff;

  // a destination written alongside the launch is used by that launch
  assign dest_eff = hi_wr_en ? hi_wr_dest : dest_q;
  assign cmd      = decode_cmd(lo_wr_data, dest_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q <= '0;
      lo_q   <= '0;
    end else begin
      if (hi_wr_en) dest_q <= hi_wr_dest;
      if (lo_wr_en) begin
        lo_q           <= lo_wr_data;
        lo_q[BUSY_BIT] <= 1'b0;
      end
    end
  end

  assign cmd_lo_rd = lo_q;

  a_r1_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr_en |=> (cmd_lo_rd[BUSY_BIT] == 1'b0));

endmodule

// File: rtl/ipi_unit_match.sv
module ipi_unit_match
  import ipi_match_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  shorthand_e       sh,
  input  logic             logical,
  input  logic [7:0]       dest,
  input  logic [IDX_W-1:0] src_unit,
  input  logic [7:0]       phys_id,
  input  logic [7:0]       log_id,
  input  logic             fmt_wr_en,
  input  logic [3:0]       fmt_wr_model,
  output logic [31:0]      fmt_rd,
  output logic             hit
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX);
  localparam logic [27:0]      FILL   = '1;

  logic [3:0] model_q;
  logic       is_self;
  logic       phys_hit;
  logic       log_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)         model_q <= FMT_FLAT;
    else if (fmt_wr_en) model_q <= fmt_wr_model;
  end

  assign fmt_rd   = {model_q, FILL};
  assign is_self  = (src_unit == MY_IDX);
  assign phys_hit = (dest == 8'hFF) || (dest == phys_id);

  always_comb begin
    case (model_q)
      FMT_FLAT:    log_hit = |(log_id & dest);
      FMT_CLUSTER: log_hit = (log_id[7:4] == dest[7:4]) && (|(log_id[3:0] & dest[3:0]));
      default:     log_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (sh)
      SH_SELF:   hit = is_self;
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = !is_self;
      default:   hit = logical ? log_hit : phys_hit;
    endcase
  end

  a_r4_phys_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (sh == SH_NONE && !logical && dest == 8'hFF) |-> hit);

endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
  parameter int unsigned NUM_UNITS = 8
) (
  input  logic [NUM_UNITS-1:0] hits,
  output logic [NUM_UNITS-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (hits[i]) pick = NUM_UNITS'(1) << i;
    end
  end
endmodule

// File: rtl/ipi_dest_matcher.sv
module ipi_dest_matcher
  import ipi_match_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8,
  localparam int unsigned IDX_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hi_wr_en,
  input  logic [7:0]             hi_wr_dest,
  input  logic                   lo_wr_en,
  input  logic [31:0]            lo_wr_data,
  input  logic [IDX_W-1:0]       src_unit,
  input  logic [8*NUM_UNITS-1:0] unit_phys_id,
  input  logic [8*NUM_UNITS-1:0] unit_log_id,
  input  logic [NUM_UNITS-1:0]   fmt_wr_en,
  input  logic [3:0]             fmt_wr_model,
  output logic [32*NUM_UNITS-1:0] fmt_rd,
  output logic [31:0]            cmd_lo_rd,
  output logic [NUM_UNITS-1:0]   dlv_strobe,
  output logic [7:0]             dlv_vector,
  output logic                   dlv_level,
  output logic                   dlv_trig,
  output logic                   dlv_lowest
);
  ipi_cmd_t             cmd;
  logic [NUM_UNITS-1:0] hits;
  logic [NUM_UNITS-1:0] pick;
  logic [NUM_UNITS-1:0] strobe_d;
  logic                 is_lowest;
  logic                 deliver;

  ipi_cmd_reg u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_wr_en   (hi_wr_en),
    .hi_wr_dest (hi_wr_dest),
    .lo_wr_en   (lo_wr_en),
    .lo_wr_data (lo_wr_data),
    .cmd        (cmd),
    .cmd_lo_rd  (cmd_lo_rd)
  );

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    ipi_unit_match #(.IDX_W(IDX_W), .IDX(g)) u_match (
      .clk          (clk),
      .rst_n        (rst_n),
      .sh           (cmd.sh),
      .logical      (cmd.logical),
      .dest         (cmd.dest),
      .src_unit     (src_unit),
      .phys_id      (unit_phys_id[8*g +: 8]),
      .log_id       (unit_log_id[8*g +: 8]),
      .fmt_wr_en    (fmt_wr_en[g]),
      .fmt_wr_model (fmt_wr_model),
      .fmt_rd       (fmt_rd[32*g +: 32]),
      .hit          (hits[g])
    );
  end

  ipi_lowest_pick #(.NUM_UNITS(NUM_UNITS)) u_pick (
    .hits (hits),
    .pick (pick)
  );

  assign is_lowest = (cmd.mode == DM_LOWEST);
  assign deliver   = lo_wr_en && (cmd.mode == DM_FIXED || is_lowest);
  assign strobe_d  = !deliver ? '0 : (is_lowest ? pick : hits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_strobe <= '0;
      dlv_vector <= '0;
      dlv_level  <= 1'b0;
      dlv_trig   <= 1'b0;
      dlv_lowest <= 1'b0;
    end else begin
      dlv_strobe <= strobe_d;
      if (lo_wr_en) begin
        dlv_vector <= cmd.vector;
        dlv_level  <= cmd.level;
        dlv_trig   <= cmd.trig;
        dlv_lowest <= is_lowest;
      end
    end
  end

  a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr_en && cmd.mode == DM_LOWEST) |=> $onehot0(dlv_strobe));

  a_r9_mode_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr_en && cmd.mode > DM_LOWEST) |=> (dlv_strobe == '0));

  a_r10_quiet_without_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_wr_en |=> (dlv_strobe == '0));

  a_r3_broadcast_all: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr_en && cmd.mode == DM_FIXED && cmd.sh == SH_ALL) |=> (&dlv_strobe));

endmodule

// File: tb/tb_ipi_dest_matcher.sv
module tb_ipi_dest_matcher;
  localparam int N  = 8;
  localparam int IW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           hi_wr_en = 1'b0;
  logic [7:0]     hi_wr_dest = '0;
  logic           lo_wr_en = 1'b0;
  logic [31:0]    lo_wr_data = '0;
  logic [IW-1:0]  src_unit = '0;
  logic [8*N-1:0] unit_phys_id;
  logic [8*N-1:0] unit_log_id;
  logic [N-1:0]   fmt_wr_en = '0;
  logic [3:0]     fmt_wr_model = '0;
  logic [32*N-1:0] fmt_rd;
  logic [31:0]    cmd_lo_rd;
  logic [N-1:0]   dlv_strobe;
  logic [7:0]     dlv_vector;
  logic           dlv_level, dlv_trig, dlv_lowest;

  logic [7:0] pid [N];
  logic [7:0] lid [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      unit_phys_id[8*i +: 8] = pid[i];
      unit_log_id[8*i +: 8]  = lid[i];
    end
  end

  ipi_dest_matcher #(.NUM_UNITS(N)) dut (.*);

  always #2 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R10";

  // ---------------- reference model ----------------
  logic [7:0]  m_dest;
  logic [31:0] m_lo;
  logic [3:0]  m_fmt [N];
  logic [N-1:0] e_strobe;
  logic [7:0]  e_vector;
  logic        e_level, e_trig, e_lowest;

  function automatic bit m_hit(int u, logic [31:0] lo, logic [7:0] d);
    int sh = int'(lo[19:18]);
    if (sh == 1) return u == int'(src_unit);
    if (sh == 2) return 1;
    if (sh == 3) return u != int'(src_unit);
    if (!lo[11]) return (d == 8'hFF) || (d == pid[u]);
    if (m_fmt[u] == 4'hF) return (lid[u] & d) != 0;
    if (m_fmt[u] == 4'h0) return (lid[u][7:4] == d[7:4]) && ((lid[u][3:0] & d[3:0]) != 0);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dest = 0; m_lo = 0; e_strobe = 0; e_vector = 0;
      e_level = 0; e_trig = 0; e_lowest = 0;
      for (int i = 0; i < N; i++) m_fmt[i] = 4'hF;
    end else begin
      logic [7:0] d;
      int mode;
      d = hi_wr_en ? hi_wr_dest : m_dest;
      e_strobe = 0;
      if (lo_wr_en) begin
        mode = int'(lo_wr_data[10:8]);
        if (mode == 0) begin
          for (int u = 0; u < N; u++) e_strobe[u] = m_hit(u, lo_wr_data, d);
        end else if (mode == 1) begin
          for (int u = 0; u < N; u++)
            if (m_hit(u, lo_wr_data, d)) e_strobe = N'(1) << u;
        end
        m_lo = lo_wr_data;
        m_lo[12] = 1'b0;
        e_vector = lo_wr_data[7:0];
        e_level  = lo_wr_data[14];
        e_trig   = lo_wr_data[15];
        e_lowest = (mode == 1);
      end
      if (hi_wr_en) m_dest = hi_wr_dest;
      for (int i = 0; i < N; i++) if (fmt_wr_en[i]) m_fmt[i] = fmt_wr_model;
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "strobe", 64'(dlv_strobe), 64'(e_strobe));
      check("R1", "vector", 64'(dlv_vector), 64'(e_vector));
      check("R1", "level/trig", 64'({dlv_level, dlv_trig}), 64'({e_level, e_trig}));
      check("R8", "lowest flag", 64'(dlv_lowest), 64'(e_lowest));
      check("R1", "low word readback", 64'(cmd_lo_rd), 64'(m_lo));
      for (int i = 0; i < N; i++)
        check("R5", "format readback", 64'(fmt_rd[32*i +: 32]), 64'({m_fmt[i], 28'hFFFFFFF}));
    end
  end

  function automatic logic [31:0] mk(int vec, int mode, int lg, int lvl, int trg, int sh);
    logic [31:0] w = '0;
    w[7:0]   = vec[7:0];
    w[10:8]  = mode[2:0];
    w[11]    = lg[0];
    w[14]    = lvl[0];
    w[15]    = trg[0];
    w[19:18] = sh[1:0];
    return w;
  endfunction

  task automatic send(input string req, input logic [7:0] d, input logic [31:0] lo, input int src);
    @(negedge clk);
    cur_req = req; hi_wr_en = 1; hi_wr_dest = d; src_unit = IW'(src);
    @(negedge clk);
    hi_wr_en = 0; lo_wr_en = 1; lo_wr_data = lo;
    @(negedge clk);
    lo_wr_en = 0;
    @(negedge clk);
  endtask

  task automatic fmt_write(input logic [N-1:0] sel, input logic [3:0] model);
    @(negedge clk);
    cur_req = "R5"; fmt_wr_en = sel; fmt_wr_model = model;
    @(negedge clk);
    fmt_wr_en = 0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      pid[i] = 8'(8'h10 + i);
      lid[i] = 8'(1 << i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R5, R10)
    check("R10", "reset strobe", 64'(dlv_strobe), 64'd0);
    check("R5", "reset format unit0", 64'(fmt_rd[31:0]), 64'hFFFFFFFF);

    // R1: fields and busy bit cleared on readback
    send("R1", 8'h13, mk(8'hA7, 0, 0, 1, 1, 0) | 32'h1000, 0);
    check("R1", "busy bit", 64'(cmd_lo_rd[12]), 64'd0);
    check("R1", "vector out", 64'(dlv_vector), 64'hA7);
    // R4 physical
    send("R4", 8'h15, mk(8'h31, 0, 0, 0, 0, 0), 1);
    send("R4", 8'hFF, mk(8'h32, 0, 0, 0, 0, 0), 1);
    send("R4", 8'h77, mk(8'h33, 0, 0, 0, 0, 0), 1);
    // R2 self, R3 all / others
    send("R2", 8'h00, mk(8'h40, 0, 0, 0, 0, 1), 5);
    send("R3", 8'h00, mk(8'h41, 0, 0, 0, 0, 2), 2);
    send("R3", 8'h00, mk(8'h42, 0, 0, 0, 0, 3), 2);
    // R6 flat
    send("R6", 8'h05, mk(8'h50, 0, 1, 0, 0, 0), 0);
    send("R6", 8'hC0, mk(8'h51, 0, 1, 1, 0, 0), 0);
    // R8 lowest priority
    send("R8", 8'h05, mk(8'h60, 1, 1, 0, 0, 0), 0);
    send("R8", 8'h00, mk(8'h61, 1, 0, 0, 0, 2), 0);
    send("R8", 8'h77, mk(8'h62, 1, 0, 0, 0, 0), 0);
    check("R8", "empty set", 64'(dlv_strobe), 64'd0);
    // R9 dropped modes
    for (int m = 2; m < 8; m++) send("R9", 8'hFF, mk(8'h70 + m, m, 0, 0, 0, 2), 0);
    // R7 cluster and R5 unknown model
    for (int i = 0; i < N; i++) lid[i] = (i < 4) ? 8'(8'h10 | (1 << i)) : 8'(8'h20 | (1 << (i - 4)));
    fmt_write('1, 4'h0);
    check("R5", "format forced ones", 64'(fmt_rd[63:32]), 64'h0FFFFFFF);
    send("R7", 8'h13, mk(8'h80, 0, 1, 0, 0, 0), 0);
    send("R7", 8'h2C, mk(8'h81, 0, 1, 0, 0, 0), 0);
    send("R7", 8'h30, mk(8'h82, 0, 1, 0, 0, 0), 0);
    fmt_write(8'h01, 4'h5);
    send("R5", 8'h13, mk(8'h83, 0, 1, 0, 0, 0), 0);
    send("R8", 8'h1F, mk(8'h84, 1, 1, 0, 0, 0), 0);
    // R10 same-cycle high and low writes, same-cycle format write
    @(negedge clk);
    cur_req = "R10"; hi_wr_en = 1; hi_wr_dest = 8'h12; lo_wr_en = 1;
    lo_wr_data = mk(8'h90, 0, 0, 0, 1, 0); fmt_wr_en = 8'h02; fmt_wr_model = 4'h7;
    @(negedge clk);
    hi_wr_en = 0; lo_wr_en = 0; fmt_wr_en = 0;
    check("R10", "same-cycle dest", 64'(dlv_strobe), 64'h04);
    @(negedge clk);
    check("R10", "one-cycle strobe", 64'(dlv_strobe), 64'd0);
    send("R10", 8'h21, mk(8'h91, 0, 1, 0, 0, 0), 0);
    // back-to-back launches
    @(negedge clk);
    lo_wr_en = 1; lo_wr_data = mk(8'hA0, 0, 0, 0, 0, 2);
    @(negedge clk);
    lo_wr_data = mk(8'hA1, 0, 0, 0, 0, 1); src_unit = 3'd6;
    @(negedge clk);
    lo_wr_en = 0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule